// File: doc/BRIEF.md
# Directional Stream Prefetch Tracker

This block follows the stream of demand load line addresses seen by a first-level cache and issues next-line prefetch requests toward the second-level cache. The goal is to get data there before the first-level miss arrives. It holds two small tracking tables. One table follows streams that move up through memory and the other follows streams that move down. The upward table is the larger one, because upward walks are the common and preferred case. Each table entry stores the line it expects the stream to touch next.

Every load is compared with both tables. A load that matches an entry confirms that entry's stream. The entry then moves one line further in its direction, and a prefetch is offered for the line after the load in that direction. A load that matches nothing starts a candidate stream in both tables. Each table gives up its least recently used entry for it. So a prefetch appears only on the second access of a stream. Prefetches never leave the 4 KB page of the load that caused them.

The load input is a strobe with no back-pressure: a load is taken in every cycle where `ld_valid` is high. The prefetch output is a valid/ready stream with at most one request in flight. An offered request stays unchanged while `pf_ready` is low. It is withdrawn, not queued, when the next load is processed. In that cycle it is replaced by the new load's request or by nothing.

Top module: `stream_prefetcher`

## Requirements
- R1: After reset `pf_valid` is low and both tables are empty, so the first load after reset never produces a prefetch.
- R2: A load at line L that matches no entry produces no prefetch. It allocates an upward entry expecting L+1 and a downward entry expecting L-1.
- R3: A load at line L that matches an upward entry raises `pf_valid` with `pf_line` = L+1 in the cycle after the load. The entry then expects L+1.
- R4: A load at line L that matches only a downward entry raises `pf_valid` with `pf_line` = L-1 in the cycle after the load. The entry then expects L-1.
- R5: When a load matches both an upward and a downward entry, the upward direction wins and the prefetch is L+1.
- R6: A page is 64 lines, given by the low 6 bits of the line address. No prefetch is issued for an upward match when the load's low 6 bits are all ones, or for a downward match when they are all zeros. The matched entry still advances.
- R7: The upward table has 16 entries with least-recently-used replacement. A stream survives 15 later allocations and is lost after 16.
- R8: The downward table has 4 entries with least-recently-used replacement. A stream survives 3 later allocations and is lost after 4.
- R9: While `pf_valid` is high, `pf_ready` is low and no load arrives, `pf_valid` and `pf_line` hold. The cycle after a handshake with no new load, `pf_valid` is low.
- R10: A load that arrives while a request is still pending replaces that request. If the new load produces no prefetch, the pending request is dropped.
- R11: `pf_valid` rises only in the cycle after a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A demand load is present this cycle |
| ld_line | input | LINE_W | Line address of the demand load |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_ready | input | 1 | The second-level cache accepts the offered request |
| pf_line | output | LINE_W | Line address to prefetch |

## Verification
The bench goes after the page edges. A design that checks the wrong end of the page would prefetch into the next page, or suppress an ordinary request near the edge. It fills each table to exactly its depth and one entry short of it. An off-by-one in the age ranking would keep an evicted stream alive, or lose one that should survive. A load that hits both tables checks the direction priority: a design that lets the downward entry win would emit L-1. Back-pressure tests check that a stalled request holds steady and is withdrawn by the next load. A design that queues would replay the stale line, and one that pulses would lose the request before it is accepted.

// File: rtl/pf_pkg.sv
package pf_pkg;
  // Direction of a tracking table.
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} pf_dir_e;

  // Default geometry: 32-bit byte address, 64-byte lines, 4 KB pages.
  localparam int unsigned DEF_LINE_W          = 26;
  localparam int unsigned DEF_PAGE_LINES_LOG2 = 6;
  localparam int unsigned DEF_UP_DEPTH        = 16;
  localparam int unsigned DEF_DOWN_DEPTH      = 4;
endpackage

// File: rtl/pf_lru.sv
module pf_lru #(
  parameter int unsigned N = 4,
  localparam int unsigned RW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_en,
  input  logic [RW-1:0] touch_idx,
  output logic [RW-1:0] victim_idx
);
  // Rank 0 is the most recent entry and rank N-1 is the next victim.
  logic [RW-1:0] rank_q [N];
  logic [RW-1:0] touched_rank;

  assign touched_rank = rank_q[touch_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) rank_q[i] <= RW'(i);
    end else if (touch_en) begin
      for (int i = 0; i < N; i++) begin
        if (RW'(i) == touch_idx)            rank_q[i] <= '0;
        else if (rank_q[i] < touched_rank)  rank_q[i] <= rank_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < N; i++)
      if (rank_q[i] == RW'(N - 1)) victim_idx = RW'(i);
  end
endmodule

// File: rtl/pf_track_table.sv
module pf_track_table
  import pf_pkg::*;
#(
  parameter int unsigned N      = 4,
  parameter int unsigned LINE_W = 26,
  parameter pf_dir_e     DIR    = DIR_UP,
  localparam int unsigned RW = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [LINE_W-1:0] lk_line,
  input  logic              alloc_en,
  output logic              hit
);
  logic              valid_q  [N];
  logic [LINE_W-1:0] expect_q [N];
  logic [N-1:0]      hit_vec;
  logic [RW-1:0]     hit_idx;
  logic [RW-1:0]     victim_idx;
  logic [RW-1:0]     touch_idx;
  logic              touch_en;
  logic [LINE_W-1:0] step_line;

  assign step_line = (DIR == DIR_DOWN) ? lk_line - 1'b1 : lk_line + 1'b1;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cmp
      assign hit_vec[g] = valid_q[g] && (expect_q[g] == lk_line);
    end
  endgenerate

  always_comb begin
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (hit_vec[i]) hit_idx = RW'(i);
  end

  assign hit       = lk_valid && (|hit_vec);
  assign touch_en  = hit || alloc_en;
  assign touch_idx = hit ? hit_idx : victim_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        valid_q[i]  <= 1'b0;
        expect_q[i] <= '0;
      end
    end else if (touch_en) begin
      valid_q[touch_idx]  <= 1'b1;
      expect_q[touch_idx] <= step_line;
    end
  end

  pf_lru #(.N(N)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_en   (touch_en),
    .touch_idx  (touch_idx),
    .victim_idx (victim_idx)
  );
endmodule

// File: rtl/pf_issue.sv
module pf_issue #(
  parameter int unsigned LINE_W          = 26,
  parameter int unsigned PAGE_LINES_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [LINE_W-1:0] ld_line,
  input  logic              hit_up,
  input  logic              hit_down,
  input  logic              pf_ready,
  output logic              pf_valid,
  output logic [LINE_W-1:0] pf_line
);
  logic at_top, at_bottom, go_up, go_down;

  assign at_top    = &ld_line[PAGE_LINES_LOG2-1:0];
  assign at_bottom = ~|ld_line[PAGE_LINES_LOG2-1:0];
  assign go_up     = hit_up && !at_top;
  assign go_down   = hit_down && !hit_up && !at_bottom;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_valid <= 1'b0;
      pf_line  <= '0;
    end else if (ld_valid) begin
      pf_valid <= go_up || go_down;
      if (go_up)        pf_line <= ld_line + 1'b1;
      else if (go_down) pf_line <= ld_line - 1'b1;
    end else if (pf_ready) begin
      pf_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/stream_prefetcher.sv
module stream_prefetcher
  import pf_pkg::*;
#(
  parameter int unsigned LINE_W          = DEF_LINE_W,
  parameter int unsigned PAGE_LINES_LOG2 = DEF_PAGE_LINES_LOG2,
  parameter int unsigned UP_DEPTH        = DEF_UP_DEPTH,
  parameter int unsigned DOWN_DEPTH      = DEF_DOWN_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [LINE_W-1:0] ld_line,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [LINE_W-1:0] pf_line
);
  logic hit_up, hit_down, alloc_en;

  assign alloc_en = ld_valid && !hit_up && !hit_down;

  pf_track_table #(.N(UP_DEPTH), .LINE_W(LINE_W), .DIR(DIR_UP)) u_up_tab (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_valid (ld_valid),
    .lk_line  (ld_line),
    .alloc_en (alloc_en),
    .hit      (hit_up)
  );

  pf_track_table #(.N(DOWN_DEPTH), .LINE_W(LINE_W), .DIR(DIR_DOWN)) u_down_tab (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_valid (ld_valid),
    .lk_line  (ld_line),
    .alloc_en (alloc_en),
    .hit      (hit_down)
  );

  pf_issue #(.LINE_W(LINE_W), .PAGE_LINES_LOG2(PAGE_LINES_LOG2)) u_issue (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_valid (ld_valid),
    .ld_line  (ld_line),
    .hit_up   (hit_up),
    .hit_down (hit_down),
    .pf_ready (pf_ready),
    .pf_valid (pf_valid),
    .pf_line  (pf_line)
  );
endmodule

// File: rtl/stream_prefetcher_chk.sv
module stream_prefetcher_chk #(
  parameter int unsigned LINE_W          = 26,
  parameter int unsigned PAGE_LINES_LOG2 = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_valid,
  input logic [LINE_W-1:0] ld_line,
  input logic              pf_valid,
  input logic              pf_ready,
  input logic [LINE_W-1:0] pf_line
);
  // R9: a stalled request holds while no load arrives.
  assert_pf_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready && !ld_valid) |=> (pf_valid && $stable(pf_line)));

  // R11: without a load, no new request can appear.
  assert_pf_origin_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_valid && !(pf_valid && !pf_ready)) |=> !pf_valid);

  // R6: a request stays in the page of its load.
  assert_pf_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> (!pf_valid ||
      pf_line[LINE_W-1:PAGE_LINES_LOG2] == $past(ld_line[LINE_W-1:PAGE_LINES_LOG2])));

  // R3 / R4: a request is for a line adjacent to its load.
  assert_pf_adjacent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> (!pf_valid || pf_line == $past(ld_line) + 1'b1
                            || pf_line == $past(ld_line) - 1'b1));
endmodule

bind stream_prefetcher stream_prefetcher_chk #(
  .LINE_W(LINE_W), .PAGE_LINES_LOG2(PAGE_LINES_LOG2)
) u_chk (.*);

// File: tb/test_stream_prefetcher.sv
module test_stream_prefetcher;
  localparam int unsigned LW = 26;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_valid = 1'b0;
  logic [LW-1:0] ld_line = '0;
  logic          pf_valid;
  logic          pf_ready = 1'b1;
  logic [LW-1:0] pf_line;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  stream_prefetcher i_stream_prefetcher (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_line(ld_line),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_line(pf_line)
  );

  task automatic chk(input string req, input logic exp_v, input int exp_line);
    checks++;
    if (pf_valid !== exp_v || (exp_v && pf_line !== LW'(exp_line))) begin
      errors++;
      $display("FAIL %s: pf_valid=%0b pf_line=%0d expected pf_valid=%0b pf_line=%0d",
               req, pf_valid, pf_line, exp_v, exp_line);
    end
  endtask

  // Presents one load, then samples the registered result one cycle later.
  task automatic send(input int line, input logic rdy);
    @(negedge clk);
    ld_valid = 1'b1;
    ld_line  = LW'(line);
    pf_ready = rdy;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 reset", 1'b0, 0);
    send(100, 1'b1);
    chk("R1 first load", 1'b0, 0);
  endtask

  task automatic t_up;
    send(101, 1'b1); chk("R3 up second", 1'b1, 102);
    send(102, 1'b1); chk("R3 up third", 1'b1, 103);
    send(7000, 1'b1); chk("R2 fresh load", 1'b0, 0);
  endtask

  task automatic t_down;
    send(500, 1'b1); chk("R2 down first", 1'b0, 0);
    send(499, 1'b1); chk("R4 down second", 1'b1, 498);
    send(498, 1'b1); chk("R4 down third", 1'b1, 497);
  endtask

  task automatic t_page;
    send(318, 1'b1);
    send(319, 1'b1); chk("R6 up page top", 1'b0, 0);
    send(320, 1'b1); chk("R6 up advanced", 1'b1, 321);
    send(641, 1'b1);
    send(640, 1'b1); chk("R6 down page bottom", 1'b0, 0);
    send(639, 1'b1); chk("R6 down advanced", 1'b1, 638);
  endtask

  task automatic t_backpressure;
    send(1000, 1'b0);
    send(1001, 1'b0); chk("R9 offered", 1'b1, 1002);
    @(negedge clk);   chk("R9 held", 1'b1, 1002);
    pf_ready = 1'b1;
    @(negedge clk);   chk("R9 accepted", 1'b0, 0);
    send(1100, 1'b0);
    send(1101, 1'b0); chk("R10 pending", 1'b1, 1102);
    send(5000, 1'b0); chk("R10 dropped", 1'b0, 0);
    pf_ready = 1'b1;
  endtask

  task automatic t_priority;
    send(8999, 1'b1);
    send(9001, 1'b1);
    send(9000, 1'b1); chk("R5 up wins", 1'b1, 9001);
  endtask

  task automatic t_lru_up;
    send(2000, 1'b1);
    for (int i = 0; i < 16; i++) send(20000 + i * 16, 1'b1);
    send(2001, 1'b1); chk("R7 evicted after 16", 1'b0, 0);
    send(3000, 1'b1);
    for (int i = 0; i < 15; i++) send(21000 + i * 16, 1'b1);
    send(3001, 1'b1); chk("R7 kept after 15", 1'b1, 3002);
  endtask

  task automatic t_lru_down;
    send(8000, 1'b1);
    for (int i = 0; i < 4; i++) send(22000 + i * 16, 1'b1);
    send(7999, 1'b1); chk("R8 evicted after 4", 1'b0, 0);
    send(8500, 1'b1);
    for (int i = 0; i < 3; i++) send(23000 + i * 16, 1'b1);
    send(8499, 1'b1); chk("R8 kept after 3", 1'b1, 8498);
  endtask

  task automatic t_idle;
    repeat (2) @(negedge clk);
    chk("R11 idle", 1'b0, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_up();
        t_down();
        t_page();
        t_backpressure();
        t_priority();
        t_lru_up();
        t_lru_down();
        t_idle();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule